// File: doc/BRIEF.md
# In-Order Completion Buffer Queue

This block keeps track of instructions between dispatch and retirement. It has five entries, used as a circular first-in-first-out list. Dispatch can claim up to two entries per cycle. Each claimed entry records the architectural destination register of its instruction and returns the entry index as a tag. Execution units report completion against that tag, with an exception flag. Entries retire strictly from the head, at most two per cycle. A retire tells the register file to copy the rename value into the named architectural register.

Each entry runs a small state machine with four states:
- FREE: not in use.
- BUSY: dispatched, with no result yet.
- DONE: finished without a fault.
- FAULT: finished with an exception.

The transitions are:
- FREE->BUSY on allocation.
- BUSY->DONE on a clean finish report.
- BUSY->FAULT on a finish report that carries the exception flag.
- DONE->FREE and FAULT->FREE on retirement.
- Any state goes to FREE on a flush.

A faulting entry retires on its own and raises a flush output that clears every younger entry. An external mispredict flush clears the whole queue. Dispatch sees a registered free count and a full flag and throttles itself on them.

Top module: `cmpl_queue`

## Requirements
- R1: After reset the queue is empty: free_cnt is 5, full is 0, ret_vld is 00 and flush_out is 0.
- R2: Allocation slot 0 is granted when alloc_req[0] is high and at least one entry is free. Slot 1 is granted only when both request bits are high and at least two entries are free. Granted tags are consecutive entry indices modulo 5, slot 0 first. After reset or any flush the first tag is 0.
- R3: With no free entry, full is high and no allocation is granted.
- R4: Entries retire only from the head, in allocation order, at most two per cycle. When ret_vld[1] is high, ret_tag1 is the index that follows ret_tag0.
- R5: The second entry retires only in a cycle where the head also retires, and only when both are finished without an exception.
- R6: ret_dst0 and ret_dst1 return the destination register recorded at allocation for the retiring entries. ret_vld marks the commit of that register.
- R7: A head entry finished with an exception retires alone, with ret_vld = 01, ret_exc = 1 and flush_out = 1 in the same cycle.
- R8: The cycle after flush_out, every entry is free (free_cnt is 5) and the next tag granted is 0.
- R9: A finish report for a tag whose entry is free, or is already finished, has no effect.
- R10: free_cnt reflects allocations and retirements of a cycle only from the following cycle.
- R11: While mispredict_flush is high, no entry retires and no allocation is granted. In the next cycle the queue is empty.
- R12: A finished entry can retire no earlier than the cycle after its finish report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 2 | Dispatch requests, slot 0 is older |
| alloc_dst0 | input | 5 | Destination register of slot 0 |
| alloc_dst1 | input | 5 | Destination register of slot 1 |
| alloc_ok | output | 2 | Grants per slot |
| alloc_tag0 | output | 3 | Tag of slot 0 |
| alloc_tag1 | output | 3 | Tag of slot 1 |
| free_cnt | output | 3 | Free entries, registered |
| full | output | 1 | No entry free, dispatch stalls |
| fin_vld | input | 2 | Finish report valid per execution port |
| fin_tag | input | 6 | Finish tags, 3 bits per port, port 0 in bits 2:0 |
| fin_exc | input | 2 | Exception flag per port |
| mispredict_flush | input | 1 | Discard all entries |
| ret_vld | output | 2 | Retire and commit, bit 1 only with bit 0 |
| ret_tag0 | output | 3 | Tag of the oldest retiring entry |
| ret_tag1 | output | 3 | Tag of the second retiring entry |
| ret_dst0 | output | 5 | Destination committed by retire 0 |
| ret_dst1 | output | 5 | Destination committed by retire 1 |
| ret_exc | output | 1 | Retire 0 carries an exception |
| flush_out | output | 1 | Exception flush of all younger entries |

## Verification
The hardest situation to reach from the ports is a finished head next to a faulting second entry. The head must retire alone, and the fault must retire one cycle later, with its flush clearing entries that were finished out of order. The stimulus fills the queue to full, finishes entries out of program order across both report ports, and finishes the last two entries together with an exception on the younger one. A long random phase then mixes dual allocations, stray and repeated finish reports, rare mispredicts and occasional exceptions. A scoreboard predicts every retire from the allocation order.

// File: rtl/cmpl_pkg.sv
`timescale 1ns/1ps
package cmpl_pkg;
    parameter int unsigned CQ_DEPTH = 5;
    parameter int unsigned CQ_DST_W = 5;
    parameter int unsigned CQ_NFIN  = 2;

    // Per-entry lifecycle
    typedef enum logic [1:0] {
        ES_FREE  = 2'd0,
        ES_BUSY  = 2'd1,
        ES_DONE  = 2'd2,
        ES_FAULT = 2'd3
    } ent_st_e;
endpackage

// File: rtl/cmpl_slot.sv
`timescale 1ns/1ps
module cmpl_slot
    import cmpl_pkg::*;
#(
    parameter int unsigned IDX   = 0,
    parameter int unsigned TAG_W = 3,
    parameter int unsigned DST_W = 5,
    parameter int unsigned NFIN  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  alloc_hit,
    input  logic [DST_W-1:0]      alloc_dst,
    input  logic [NFIN-1:0]       fin_vld,
    input  logic [NFIN*TAG_W-1:0] fin_tag,
    input  logic [NFIN-1:0]       fin_exc,
    input  logic                  ret_hit,
    output ent_st_e               st,
    output logic [DST_W-1:0]      dst
);
    ent_st_e          st_q, st_n;
    logic [DST_W-1:0] dst_q;
    logic             fin_hit, fin_bad;

    // Match finish reports against this entry's index
    always_comb begin
        fin_hit = 1'b0;
        fin_bad = 1'b0;
        for (int k = 0; k < NFIN; k++) begin
            if (fin_vld[k] && fin_tag[k*TAG_W +: TAG_W] == TAG_W'(IDX)) begin
                fin_hit = 1'b1;
                fin_bad = fin_bad | fin_exc[k];
            end
        end
    end

    // Next-state process
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ES_FREE:  if (alloc_hit) st_n = ES_BUSY;
            ES_BUSY:  if (fin_hit)   st_n = fin_bad ? ES_FAULT : ES_DONE;
            ES_DONE:  if (ret_hit)   st_n = ES_FREE;
            ES_FAULT: if (ret_hit)   st_n = ES_FREE;
        endcase
        if (clear) st_n = ES_FREE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ES_FREE;
            dst_q <= '0;
        end else begin
            st_q <= st_n;
            if (alloc_hit && !clear) dst_q <= alloc_dst;
        end
    end

    assign st  = st_q;
    assign dst = dst_q;

    AST_STRAY_FIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ES_FREE && fin_hit && !alloc_hit) |=> (st_q == ES_FREE || st_q == ES_BUSY)) else $error("stray finish"); // R9
    AST_RET_NEEDS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit |-> (st_q == ES_DONE || st_q == ES_FAULT)) else $error("retire of unfinished entry"); // R4
endmodule

// File: rtl/cmpl_ptr.sv
`timescale 1ns/1ps
module cmpl_ptr #(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned TAG_W = 3,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [1:0]       alloc_req,
    input  logic [1:0]       n_ret,
    output logic [1:0]       alloc_ok,
    output logic [TAG_W-1:0] tag0,
    output logic [TAG_W-1:0] tag1,
    output logic [TAG_W-1:0] head,
    output logic [CNT_W-1:0] free_cnt,
    output logic             full
);
    logic [TAG_W-1:0] head_q, tail_q, head_n, tail_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, free_w;
    logic [1:0]       n_alloc;

    function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + TAG_W'(1);
    endfunction

    function automatic logic [TAG_W-1:0] adv(input logic [TAG_W-1:0] p, input logic [1:0] n);
        logic [TAG_W-1:0] r;
        r = p;
        if (n != 2'd0) r = nxt(r);
        if (n == 2'd2) r = nxt(r);
        return r;
    endfunction

    assign free_w = CNT_W'(DEPTH) - cnt_q;

    always_comb begin
        alloc_ok = 2'b00;
        if (!clear) begin
            alloc_ok[0] = alloc_req[0] && (free_w >= CNT_W'(1));
            alloc_ok[1] = alloc_req[0] && alloc_req[1] && (free_w >= CNT_W'(2));
        end
        n_alloc = {1'b0, alloc_ok[0]} + {1'b0, alloc_ok[1]};
        if (clear) begin
            head_n = '0;
            tail_n = '0;
            cnt_n  = '0;
        end else begin
            head_n = adv(head_q, n_ret);
            tail_n = adv(tail_q, n_alloc);
            cnt_n  = cnt_q + CNT_W'(n_alloc) - CNT_W'(n_ret);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= head_n;
            tail_q <= tail_n;
            cnt_q  <= cnt_n;
        end
    end

    assign tag0     = tail_q;
    assign tag1     = nxt(tail_q);
    assign head     = head_q;
    assign free_cnt = free_w;
    assign full     = (cnt_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)) else $error("occupancy overflow"); // R3
    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(n_ret) <= cnt_q) else $error("retire from empty queue"); // R4
endmodule

// File: rtl/cmpl_retire.sv
`timescale 1ns/1ps
module cmpl_retire
    import cmpl_pkg::*;
#(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned TAG_W = 3,
    parameter int unsigned DST_W = 5
) (
    input  ent_st_e          st [DEPTH],
    input  logic [DST_W-1:0] dst [DEPTH],
    input  logic [TAG_W-1:0] head,
    input  logic             ext_flush,
    output logic [1:0]       ret_vld,
    output logic [TAG_W-1:0] ret_tag0,
    output logic [TAG_W-1:0] ret_tag1,
    output logic [DST_W-1:0] ret_dst0,
    output logic [DST_W-1:0] ret_dst1,
    output logic             ret_exc,
    output logic             exc_flush,
    output logic [1:0]       n_ret
);
    logic [TAG_W-1:0] h1;
    ent_st_e          s0, s1;

    function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + TAG_W'(1);
    endfunction

    always_comb begin
        h1 = nxt(head);
        s0 = st[head];
        s1 = st[h1];
        ret_vld[0] = !ext_flush && (s0 == ES_DONE || s0 == ES_FAULT);
        ret_exc    = ret_vld[0] && (s0 == ES_FAULT);
        ret_vld[1] = ret_vld[0] && !ret_exc && (s1 == ES_DONE);
        exc_flush  = ret_exc;
        n_ret      = {1'b0, ret_vld[0]} + {1'b0, ret_vld[1]};
        ret_tag0   = head;
        ret_tag1   = h1;
        ret_dst0   = dst[head];
        ret_dst1   = dst[h1];
    end
endmodule

// File: rtl/cmpl_queue.sv
`timescale 1ns/1ps
module cmpl_queue
    import cmpl_pkg::*;
#(
    parameter int unsigned DEPTH = CQ_DEPTH,
    parameter int unsigned DST_W = CQ_DST_W,
    parameter int unsigned NFIN  = CQ_NFIN,
    localparam int unsigned TAG_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            alloc_req,
    input  logic [DST_W-1:0]      alloc_dst0,
    input  logic [DST_W-1:0]      alloc_dst1,
    output logic [1:0]            alloc_ok,
    output logic [TAG_W-1:0]      alloc_tag0,
    output logic [TAG_W-1:0]      alloc_tag1,
    output logic [CNT_W-1:0]      free_cnt,
    output logic                  full,
    input  logic [NFIN-1:0]       fin_vld,
    input  logic [NFIN*TAG_W-1:0] fin_tag,
    input  logic [NFIN-1:0]       fin_exc,
    input  logic                  mispredict_flush,
    output logic [1:0]            ret_vld,
    output logic [TAG_W-1:0]      ret_tag0,
    output logic [TAG_W-1:0]      ret_tag1,
    output logic [DST_W-1:0]      ret_dst0,
    output logic [DST_W-1:0]      ret_dst1,
    output logic                  ret_exc,
    output logic                  flush_out
);
    ent_st_e          st   [DEPTH];
    logic [DST_W-1:0] sdst [DEPTH];
    logic [DEPTH-1:0] alloc_hit, ret_hit;
    logic [TAG_W-1:0] head;
    logic [1:0]       n_ret;
    logic             exc_flush, clear;

    assign clear     = mispredict_flush | exc_flush;
    assign flush_out = exc_flush;

    cmpl_ptr #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .alloc_req(alloc_req),
        .n_ret    (n_ret),
        .alloc_ok (alloc_ok),
        .tag0     (alloc_tag0),
        .tag1     (alloc_tag1),
        .head     (head),
        .free_cnt (free_cnt),
        .full     (full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic             hit0;
        logic [DST_W-1:0] din;
        assign hit0         = alloc_ok[0] && (alloc_tag0 == TAG_W'(g));
        assign alloc_hit[g] = hit0 || (alloc_ok[1] && (alloc_tag1 == TAG_W'(g)));
        assign din          = hit0 ? alloc_dst0 : alloc_dst1;
        assign ret_hit[g]   = (ret_vld[0] && (ret_tag0 == TAG_W'(g)))
                           || (ret_vld[1] && (ret_tag1 == TAG_W'(g)));
        cmpl_slot #(.IDX(g), .TAG_W(TAG_W), .DST_W(DST_W), .NFIN(NFIN)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .alloc_hit(alloc_hit[g]),
            .alloc_dst(din),
            .fin_vld  (fin_vld),
            .fin_tag  (fin_tag),
            .fin_exc  (fin_exc),
            .ret_hit  (ret_hit[g]),
            .st       (st[g]),
            .dst      (sdst[g])
        );
    end

    cmpl_retire #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DST_W(DST_W)) u_retire (
        .st       (st),
        .dst      (sdst),
        .head     (head),
        .ext_flush(mispredict_flush),
        .ret_vld  (ret_vld),
        .ret_tag0 (ret_tag0),
        .ret_tag1 (ret_tag1),
        .ret_dst0 (ret_dst0),
        .ret_dst1 (ret_dst1),
        .ret_exc  (ret_exc),
        .exc_flush(exc_flush),
        .n_ret    (n_ret)
    );

    logic [CNT_W-1:0] n_alloc_c, n_ret_c;
    assign n_alloc_c = CNT_W'(alloc_ok[0]) + CNT_W'(alloc_ok[1]);
    assign n_ret_c   = CNT_W'(ret_vld[0]) + CNT_W'(ret_vld[1]);

    function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + TAG_W'(1);
    endfunction

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0) |-> (alloc_ok == 2'b00)) else $error("grant while full"); // R3
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld[1] |-> (ret_vld[0] && ret_tag1 == nxt(ret_tag0))) else $error("pair out of order"); // R4
    AST_FAULT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_exc |-> (ret_vld == 2'b01 && flush_out)) else $error("fault not alone"); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_out || mispredict_flush) |=> (free_cnt == CNT_W'(DEPTH))) else $error("flush left entries"); // R8
    AST_FREE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_out && !mispredict_flush) |=>
        (free_cnt == $past(free_cnt) + $past(n_ret_c) - $past(n_alloc_c))) else $error("free count timing"); // R10
    AST_MISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_flush |-> (ret_vld == 2'b00 && alloc_ok == 2'b00)) else $error("activity during mispredict"); // R11
endmodule

// File: tb/test_cmpl_queue.sv
`timescale 1ns/1ps
module test_cmpl_queue;
    localparam int DEPTH = 5;
    localparam int TAG_W = 3;
    localparam int DST_W = 5;
    localparam int NFIN  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]            alloc_req = '0;
    logic [DST_W-1:0]      alloc_dst0 = '0, alloc_dst1 = '0;
    logic [1:0]            alloc_ok;
    logic [TAG_W-1:0]      alloc_tag0, alloc_tag1;
    logic [2:0]            free_cnt;
    logic                  full;
    logic [NFIN-1:0]       fin_vld = '0;
    logic [NFIN*TAG_W-1:0] fin_tag = '0;
    logic [NFIN-1:0]       fin_exc = '0;
    logic                  mispredict_flush = 1'b0;
    logic [1:0]            ret_vld;
    logic [TAG_W-1:0]      ret_tag0, ret_tag1;
    logic [DST_W-1:0]      ret_dst0, ret_dst1;
    logic                  ret_exc, flush_out;

    cmpl_queue i_cmpl_queue (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_dst0(alloc_dst0),
        .alloc_dst1(alloc_dst1), .alloc_ok(alloc_ok), .alloc_tag0(alloc_tag0),
        .alloc_tag1(alloc_tag1), .free_cnt(free_cnt), .full(full), .fin_vld(fin_vld),
        .fin_tag(fin_tag), .fin_exc(fin_exc), .mispredict_flush(mispredict_flush),
        .ret_vld(ret_vld), .ret_tag0(ret_tag0), .ret_tag1(ret_tag1), .ret_dst0(ret_dst0),
        .ret_dst1(ret_dst1), .ret_exc(ret_exc), .flush_out(flush_out)
    );

    typedef struct {
        logic [TAG_W-1:0] tag;
        logic [DST_W-1:0] dst;
        bit               fin;
        bit               exc;
        int               fcyc;
    } item_t;

    item_t            sbq[$];
    logic [TAG_W-1:0] mtail = '0;
    int               cyc = 0;
    int               nchk = 0;
    int               nerr = 0;
    bit               done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    function automatic logic [TAG_W-1:0] nx(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic bit ready(input int i);
        return sbq[i].fin && (cyc > sbq[i].fcyc);
    endfunction

    // Finish reports only land on entries that are queued and not yet finished (R9)
    task automatic mark(input logic [TAG_W-1:0] t, input bit e);
        foreach (sbq[i]) begin
            if (sbq[i].tag == t && !sbq[i].fin) begin
                sbq[i].fin  = 1;
                sbq[i].exc  = e;
                sbq[i].fcyc = cyc;
            end
        end
    endtask

    task automatic begin_cycle();
        @(posedge clk);
        #1;
        alloc_req = '0;
        fin_vld = '0;
        fin_exc = '0;
        mispredict_flush = 1'b0;
    endtask

    // Driver: predicts grants and pushes expected items in program order
    task automatic end_cycle();
        int         fsz;
        bit         mfl;
        logic [1:0] eok;
        #1;
        for (int k = 0; k < NFIN; k++)
            if (fin_vld[k]) mark(fin_tag[k*TAG_W +: TAG_W], fin_exc[k]);
        fsz = DEPTH - sbq.size();
        chk(free_cnt == fsz, "R10", free_cnt, fsz);
        chk(full == (fsz == 0), "R3", full, fsz == 0);
        mfl = mispredict_flush || (sbq.size() > 0 && ready(0) && sbq[0].exc);
        eok[0] = !mfl && alloc_req[0] && fsz >= 1;
        eok[1] = !mfl && alloc_req[0] && alloc_req[1] && fsz >= 2;
        chk(alloc_ok == eok, "R2", alloc_ok, eok);
        if (eok[0]) begin
            chk(alloc_tag0 == mtail, "R2", alloc_tag0, mtail);
            sbq.push_back('{tag: mtail, dst: alloc_dst0, fin: 0, exc: 0, fcyc: 0});
            mtail = nx(mtail);
        end
        if (eok[1]) begin
            chk(alloc_tag1 == mtail, "R2", alloc_tag1, mtail);
            sbq.push_back('{tag: mtail, dst: alloc_dst1, fin: 0, exc: 0, fcyc: 0});
            mtail = nx(mtail);
        end
        if (mispredict_flush) begin
            sbq.delete();
            mtail = '0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            begin_cycle();
            end_cycle();
        end
    endtask

    // Monitor: pops and compares retirements
    bit e0, e1, eexc;
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            e0   = !mispredict_flush && sbq.size() > 0 && ready(0);
            eexc = e0 && sbq[0].exc;
            e1   = e0 && !eexc && sbq.size() > 1 && ready(1) && !sbq[1].exc;
            chk(ret_vld == {e1, e0}, "R5", ret_vld, {e1, e0});
            chk(flush_out == eexc, "R7", flush_out, eexc);
            if (e0) begin
                chk(ret_tag0 == sbq[0].tag, "R4", ret_tag0, sbq[0].tag);
                chk(ret_dst0 == sbq[0].dst, "R6", ret_dst0, sbq[0].dst);
                chk(ret_exc == eexc, "R7", ret_exc, eexc);
            end
            if (e1) begin
                chk(ret_tag1 == sbq[1].tag, "R4", ret_tag1, sbq[1].tag);
                chk(ret_dst1 == sbq[1].dst, "R6", ret_dst1, sbq[1].dst);
            end
            if (eexc) begin
                sbq.delete();
                mtail = '0;
            end else begin
                if (e0) void'(sbq.pop_front());
                if (e1) void'(sbq.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        begin_cycle();
        end_cycle();
        chk(free_cnt == DEPTH, "R1", free_cnt, DEPTH);
        chk(ret_vld == 2'b00 && !flush_out && !full, "R1", ret_vld, 0);

        // Fill: 2 + 2, then only one slot left, then full
        begin_cycle(); alloc_req = 2'b11; alloc_dst0 = 5'd10; alloc_dst1 = 5'd11; end_cycle();
        begin_cycle(); alloc_req = 2'b11; alloc_dst0 = 5'd12; alloc_dst1 = 5'd13; end_cycle();
        begin_cycle(); alloc_req = 2'b11; alloc_dst0 = 5'd14; alloc_dst1 = 5'd15; end_cycle();
        chk(alloc_ok == 2'b01, "R2", alloc_ok, 1);
        begin_cycle(); alloc_req = 2'b01; end_cycle();
        chk(full && alloc_ok == 2'b00, "R3", alloc_ok, 0);

        // Out-of-order finish: tag 2 first, head not done
        begin_cycle(); fin_vld = 2'b01; fin_tag[2:0] = 3'd2; end_cycle();
        chk(ret_vld == 2'b00, "R12", ret_vld, 0);
        idle(1);
        chk(ret_vld == 2'b00, "R4", ret_vld, 0);
        begin_cycle(); fin_vld = 2'b01; fin_tag[2:0] = 3'd0; end_cycle();
        idle(1);
        chk(ret_vld == 2'b01, "R5", ret_vld, 1);
        chk(free_cnt == 0, "R10", free_cnt, 0);
        idle(1);
        chk(free_cnt == 1, "R10", free_cnt, 1);
        begin_cycle(); fin_vld = 2'b01; fin_tag[2:0] = 3'd1; end_cycle();
        idle(1);
        chk(ret_vld == 2'b11, "R4", ret_vld, 3);
        // Tag 3 clean, tag 4 faulting, same cycle on both ports
        begin_cycle(); fin_vld = 2'b11; fin_tag = {3'd4, 3'd3}; fin_exc = 2'b10; end_cycle();
        idle(1);
        chk(ret_vld == 2'b01 && !ret_exc, "R5", ret_vld, 1);
        idle(1);
        chk(ret_exc && flush_out, "R7", ret_exc, 1);
        idle(1);
        chk(free_cnt == DEPTH, "R8", free_cnt, DEPTH);

        // Exception with younger entries pending
        begin_cycle(); alloc_req = 2'b11; alloc_dst0 = 5'd20; alloc_dst1 = 5'd21; end_cycle();
        begin_cycle(); alloc_req = 2'b11; alloc_dst0 = 5'd22; alloc_dst1 = 5'd23; end_cycle();
        begin_cycle(); fin_vld = 2'b11; fin_tag = {3'd3, 3'd0}; fin_exc = 2'b01; end_cycle();
        idle(1);
        chk(flush_out, "R7", flush_out, 1);
        idle(1);
        chk(free_cnt == DEPTH, "R8", free_cnt, DEPTH);

        // Stray finish on a free entry, then allocate it
        begin_cycle(); fin_vld = 2'b01; fin_tag[2:0] = 3'd1; end_cycle();
        begin_cycle(); alloc_req = 2'b11; alloc_dst0 = 5'd7; alloc_dst1 = 5'd8; end_cycle();
        idle(3);
        chk(ret_vld == 2'b00, "R9", ret_vld, 0);
        begin_cycle(); fin_vld = 2'b11; fin_tag = {3'd1, 3'd0}; end_cycle();
        begin_cycle(); fin_vld = 2'b01; fin_tag[2:0] = 3'd1; fin_exc = 2'b01; end_cycle();
        chk(ret_vld == 2'b11 && !ret_exc, "R9", ret_vld, 3);
        idle(2);

        // Mispredict flush suppresses retire and allocation
        begin_cycle(); alloc_req = 2'b11; alloc_dst0 = 5'd3; alloc_dst1 = 5'd4; end_cycle();
        begin_cycle(); fin_vld = 2'b11; fin_tag = {3'd3, 3'd2}; end_cycle();
        begin_cycle(); mispredict_flush = 1'b1; alloc_req = 2'b11; end_cycle();
        chk(ret_vld == 2'b00 && alloc_ok == 2'b00, "R11", ret_vld, 0);
        idle(1);
        chk(free_cnt == DEPTH, "R11", free_cnt, DEPTH);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            begin_cycle();
            alloc_req  = 2'($urandom_range(0, 3));
            alloc_dst0 = 5'($urandom);
            alloc_dst1 = 5'($urandom);
            fin_vld    = 2'($urandom_range(0, 3));
            fin_tag[2:0] = 3'($urandom_range(0, DEPTH - 1));
            fin_tag[5:3] = 3'($urandom_range(0, DEPTH - 1));
            if (fin_tag[5:3] == fin_tag[2:0]) fin_vld[1] = 1'b0;
            fin_exc[0] = ($urandom_range(0, 19) == 0);
            fin_exc[1] = ($urandom_range(0, 19) == 0);
            mispredict_flush = ($urandom_range(0, 49) == 0);
            end_cycle();
        end
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule